// File: doc/BRIEF.md
# Four-Region Circular Queue Manager

This block keeps four circular queues of 32-bit frame addresses inside one memory window. The window starts at a configurable base and is cut into four equal consecutive regions. From the base upward they hold the inbound free, inbound post, outbound free and outbound post queues. Each region is `size_code << 11` bytes long and each entry takes 4 bytes. Every queue has a head pointer and a tail pointer, both held as byte addresses. An internal entry memory stores the queued words.

Two agents use the block. The local side sees a configuration bus with the base, control, status and pointer registers, plus two local queue ports. The remote side sees two single-word ports. On either side, reading a port pops one entry and writing a port pushes one. Every queue is pushed from one side and popped from the other, so the two sides can touch the same queue in the same cycle.

Reading an empty queue returns an all-ones sentinel. A push into a full queue is refused, and for the two remote-pushed queues it sets a sticky overflow flag. A live post flag shows that the inbound post queue holds work.

Top module: `circq_mgr`

## Requirements
- R1: A local write to BASE (address 0) is accepted only when its low 20 bits are zero. A misaligned write leaves BASE unchanged and leaves every pointer unchanged.
- R2: An accepted BASE write moves the head and tail of queue q to BASE + q*(code<<11). The queue numbers are q=0 inbound free, 1 inbound post, 2 outbound free, 3 outbound post. Head q reads at address 3+2q and tail q reads at address 4+2q.
- R3: A push stores the word at the head and advances the head by 4. A pop returns the word at the tail and advances the tail by 4, so entries come out in FIFO order. The port map is as follows. A remote port 0 write pushes inbound post and a remote port 0 read pops inbound free. A remote port 1 write pushes outbound free and a remote port 1 read pops outbound post. A local address 11 write pushes inbound free and a local address 11 read pops inbound post. A local address 12 write pushes outbound post and a local address 12 read pops outbound free.
- R4: A pointer that advances to the end of its region continues at the start of the same region.
- R5: A pop from an empty queue (head equal to tail) returns 0xFFFFFFFF and moves no pointer.
- R6: A push is refused when the advanced head would equal the tail. The head does not move and the word is not stored, so a region of N entries holds at most N-1 entries.
- R7: A refused remote push sets a sticky overflow flag in STAT (address 2). Bit 7 is for inbound post and bit 8 is for outbound free. Writing 1 to a bit clears it, and a new overflow in the same cycle wins over the clear.
- R8: STAT bit 5 is 1 exactly while inbound post is non-empty. Output attn is the OR of all STAT bits.
- R9: CTRL (address 1) bit 0 enables the queues. While it is 0, every port read returns 0xFFFFFFFF and every port write is ignored. Clearing the bit leaves all pointers and entries intact.
- R10: CTRL bits [10:8] hold the size code, and CTRL resets to 0x100. A CTRL write whose code is 0 or above MAX_CODE (default 1) is rejected whole.
- R11: After reset BASE is 0, STAT is 0, both read-data outputs are 0, and queue q has head and tail at q*0x800.
- R12: A push and a pop on the same queue in the same cycle both take effect. Each judges empty and full on the pointers as they stood before that cycle, so a pop of an empty queue returns the sentinel even while a push lands.
- R13: Read data appears on loc_rdata or rem_rdata in the cycle after the read strobe. It holds until the next read on that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_addr | input | 4 | Local register address |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, registered |
| rem_wr | input | 1 | Remote port write (push) |
| rem_rd | input | 1 | Remote port read (pop) |
| rem_sel | input | 1 | Remote port select: 0 inbound, 1 outbound |
| rem_wdata | input | 32 | Remote write data |
| rem_rdata | output | 32 | Remote read data, registered |
| attn | output | 1 | Any status bit set |

## Verification
The two sides can act on the same queue in the same cycle: the remote side pushes inbound post while the local side pops it, and the remote side pushes outbound free while the local side writes STAT. The bench drives both strobes in one cycle. It does this first on an empty inbound post queue, where the pop must return the sentinel and the pushed word must come out on the next pop. It does it again on a one-entry queue, where the older word must come out. With outbound free full, a refused remote push and a clearing STAT write fall in the same cycle, and bit 8 must read back as set.

// File: rtl/qm_pkg.sv
package qm_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NUM_Q  = 4;

    // queue numbers, also their region order from the base
    localparam logic [1:0] Q_IN_FREE  = 2'd0;
    localparam logic [1:0] Q_IN_POST  = 2'd1;
    localparam logic [1:0] Q_OUT_FREE = 2'd2;
    localparam logic [1:0] Q_OUT_POST = 2'd3;

    // local register map
    localparam logic [3:0] RA_BASE  = 4'd0;
    localparam logic [3:0] RA_CTRL  = 4'd1;
    localparam logic [3:0] RA_STAT  = 4'd2;
    localparam logic [3:0] RA_PTR0  = 4'd3;
    localparam logic [3:0] RA_LPORT_A = 4'd11;
    localparam logic [3:0] RA_LPORT_B = 4'd12;

    localparam int unsigned CTRL_CODE_LSB = 8;
    localparam int unsigned ST_POST  = 5;
    localparam int unsigned ST_IPOVF = 7;
    localparam int unsigned ST_OFOVF = 8;

    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;
endpackage

// File: rtl/qm_ring.sv
module qm_ring #(
    parameter int unsigned AW = 32,
    parameter logic [AW-1:0] RST_PTR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic          init_i,
    input  logic          head_wr_i,
    input  logic          tail_wr_i,
    input  logic [AW-1:0] sw_ptr_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] head_o,
    output logic [AW-1:0] tail_o,
    output logic          empty_o,
    output logic          full_o
);
    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
    } ring_t;

    ring_t r_q, r_d;
    logic [AW-1:0] head_adv, tail_adv;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                           input logic [AW-1:0] lo,
                                           input logic [AW-1:0] hi);
        logic [AW-1:0] n;
        n = p + AW'(4);
        return (n == hi) ? lo : n;
    endfunction

    assign head_adv = step(r_q.head, lo_i, hi_i);
    assign tail_adv = step(r_q.tail, lo_i, hi_i);
    assign empty_o  = (r_q.head == r_q.tail);
    assign full_o   = (head_adv == r_q.tail);
    assign head_o   = r_q.head;
    assign tail_o   = r_q.tail;

    always_comb begin
        r_d = r_q;
        if (init_i) begin
            r_d.head = lo_i;
            r_d.tail = lo_i;
        end else begin
            if (head_wr_i)
                r_d.head = sw_ptr_i;
            else if (push_i && !full_o)
                r_d.head = head_adv;
            if (tail_wr_i)
                r_d.tail = sw_ptr_i;
            else if (pop_i && !empty_o)
                r_d.tail = tail_adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.head <= RST_PTR;
            r_q.tail <= RST_PTR;
        end else begin
            r_q <= r_d;
        end
    end

    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !init_i && !head_wr_i) |=> (head_o == $past(head_o)));

    assert_empty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !init_i && !tail_wr_i) |=> (tail_o == $past(tail_o)));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !init_i && !head_wr_i && (head_o + AW'(4) == hi_i))
        |=> (head_o == $past(lo_i)));

    assert_init_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> empty_o);
endmodule

// File: rtl/qm_store.sv
module qm_store #(
    parameter int unsigned DW = 32,
    parameter int unsigned ENTRIES = 2048,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [IW-1:0] wa_a,
    input  logic [DW-1:0] wd_a,
    input  logic          we_b,
    input  logic [IW-1:0] wa_b,
    input  logic [DW-1:0] wd_b,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    logic [DW-1:0] mem [ENTRIES];

    // the two write ports always serve different queues
    always_ff @(posedge clk) begin
        if (we_a) mem[wa_a] <= wd_a;
        if (we_b) mem[wa_b] <= wd_b;
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
endmodule

// File: rtl/circq_mgr.sv
module circq_mgr
    import qm_pkg::*;
#(
    parameter int unsigned SIZE_SHIFT = 11,
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned MAX_CODE   = 1,
    parameter int unsigned ALIGN_BITS = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        loc_wr,
    input  logic        loc_rd,
    input  logic [3:0]  loc_addr,
    input  logic [31:0] loc_wdata,
    output logic [31:0] loc_rdata,
    input  logic        rem_wr,
    input  logic        rem_rd,
    input  logic        rem_sel,
    input  logic [31:0] rem_wdata,
    output logic [31:0] rem_rdata,
    output logic        attn
);
    localparam int unsigned MEM_ENTRIES = NUM_Q * MAX_CODE * (2 ** (SIZE_SHIFT - 2));
    localparam int unsigned IW = $clog2(MEM_ENTRIES);
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(1);

    typedef struct packed {
        logic [31:0]       base;
        logic              en;
        logic [CODE_W-1:0] code;
        logic              ip_ovf;
        logic              of_ovf;
        logic [31:0]       lrd;
        logic [31:0]       rrd;
    } top_t;

    top_t r_q, r_d;

    logic [31:0] head_w [NUM_Q];
    logic [31:0] tail_w [NUM_Q];
    logic [31:0] lo_w   [NUM_Q];
    logic [31:0] hi_w   [NUM_Q];
    logic [NUM_Q-1:0] empty_w, full_w, push_w, pop_w, hwr_w, twr_w;

    logic        base_ok, ptr_hit, hit_lpa, hit_lpb;
    logic [2:0]  ptr_rel;
    logic [31:0] base_sel, len_w, stat_w;
    logic [CODE_W-1:0] wcode;
    logic        code_ok;
    logic        mem_we_a, mem_we_b;
    logic [IW-1:0] mem_wa_a, mem_wa_b, mem_ra_a, mem_ra_b;
    logic [31:0] mem_rd_a, mem_rd_b;

    function automatic logic [IW-1:0] slot(input logic [31:0] p, input logic [31:0] b);
        return IW'((p - b) >> 2);
    endfunction

    // ---------------- decode ----------------
    assign hit_lpa  = (loc_addr == RA_LPORT_A);
    assign hit_lpb  = (loc_addr == RA_LPORT_B);
    assign ptr_hit  = (loc_addr >= RA_PTR0) && (loc_addr < RA_PTR0 + 4'd8);
    assign ptr_rel  = 3'(loc_addr - RA_PTR0);
    assign base_ok  = loc_wr && (loc_addr == RA_BASE) && (loc_wdata[ALIGN_BITS-1:0] == '0);
    assign base_sel = base_ok ? loc_wdata : r_q.base;
    assign len_w    = 32'(r_q.code) << SIZE_SHIFT;
    assign wcode    = loc_wdata[CTRL_CODE_LSB +: CODE_W];
    assign code_ok  = (wcode != '0) && (32'(wcode) <= MAX_CODE);

    // each queue has one pusher and one popper, on opposite sides
    always_comb begin
        push_w = '0;
        pop_w  = '0;
        push_w[Q_IN_FREE]  = r_q.en && loc_wr && hit_lpa;
        pop_w [Q_IN_FREE]  = r_q.en && rem_rd && !rem_sel;
        push_w[Q_IN_POST]  = r_q.en && rem_wr && !rem_sel;
        pop_w [Q_IN_POST]  = r_q.en && loc_rd && hit_lpa;
        push_w[Q_OUT_FREE] = r_q.en && rem_wr && rem_sel;
        pop_w [Q_OUT_FREE] = r_q.en && loc_rd && hit_lpb;
        push_w[Q_OUT_POST] = r_q.en && loc_wr && hit_lpb;
        pop_w [Q_OUT_POST] = r_q.en && rem_rd && rem_sel;
    end

    // ---------------- queues ----------------
    for (genvar q = 0; q < NUM_Q; q++) begin : g_ring
        assign lo_w[q]  = base_sel + 32'(q) * len_w;
        assign hi_w[q]  = lo_w[q] + len_w;
        assign hwr_w[q] = loc_wr && ptr_hit && (ptr_rel[2:1] == 2'(q)) && !ptr_rel[0];
        assign twr_w[q] = loc_wr && ptr_hit && (ptr_rel[2:1] == 2'(q)) &&  ptr_rel[0];

        qm_ring #(
            .AW      (32),
            .RST_PTR (32'(q) << SIZE_SHIFT)
        ) ring_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .lo_i      (lo_w[q]),
            .hi_i      (hi_w[q]),
            .init_i    (base_ok),
            .head_wr_i (hwr_w[q]),
            .tail_wr_i (twr_w[q]),
            .sw_ptr_i  (loc_wdata),
            .push_i    (push_w[q]),
            .pop_i     (pop_w[q]),
            .head_o    (head_w[q]),
            .tail_o    (tail_w[q]),
            .empty_o   (empty_w[q]),
            .full_o    (full_w[q])
        );
    end

    // ---------------- entry memory ----------------
    // port A serves local pushes/pops, port B remote ones
    assign mem_we_a = (push_w[Q_IN_FREE] && !full_w[Q_IN_FREE]) ||
                      (push_w[Q_OUT_POST] && !full_w[Q_OUT_POST]);
    assign mem_wa_a = hit_lpa ? slot(head_w[Q_IN_FREE], r_q.base)
                              : slot(head_w[Q_OUT_POST], r_q.base);
    assign mem_we_b = (push_w[Q_IN_POST] && !full_w[Q_IN_POST]) ||
                      (push_w[Q_OUT_FREE] && !full_w[Q_OUT_FREE]);
    assign mem_wa_b = rem_sel ? slot(head_w[Q_OUT_FREE], r_q.base)
                              : slot(head_w[Q_IN_POST], r_q.base);
    assign mem_ra_a = hit_lpa ? slot(tail_w[Q_IN_POST], r_q.base)
                              : slot(tail_w[Q_OUT_FREE], r_q.base);
    assign mem_ra_b = rem_sel ? slot(tail_w[Q_OUT_POST], r_q.base)
                              : slot(tail_w[Q_IN_FREE], r_q.base);

    qm_store #(
        .DW      (32),
        .ENTRIES (MEM_ENTRIES)
    ) store_i (
        .clk  (clk),
        .we_a (mem_we_a),
        .wa_a (mem_wa_a),
        .wd_a (loc_wdata),
        .we_b (mem_we_b),
        .wa_b (mem_wa_b),
        .wd_b (rem_wdata),
        .ra_a (mem_ra_a),
        .ra_b (mem_ra_b),
        .rd_a (mem_rd_a),
        .rd_b (mem_rd_b)
    );

    // ---------------- status ----------------
    always_comb begin
        stat_w = '0;
        stat_w[ST_POST]  = !empty_w[Q_IN_POST];
        stat_w[ST_IPOVF] = r_q.ip_ovf;
        stat_w[ST_OFOVF] = r_q.of_ovf;
    end
    assign attn = |stat_w;

    // ---------------- next state ----------------
    always_comb begin
        r_d = r_q;

        if (base_ok)
            r_d.base = loc_wdata;

        if (loc_wr && (loc_addr == RA_CTRL) && code_ok) begin
            r_d.en   = loc_wdata[0];
            r_d.code = wcode;
        end

        if (loc_wr && (loc_addr == RA_STAT)) begin
            if (loc_wdata[ST_IPOVF]) r_d.ip_ovf = 1'b0;
            if (loc_wdata[ST_OFOVF]) r_d.of_ovf = 1'b0;
        end
        if (push_w[Q_IN_POST] && full_w[Q_IN_POST])   r_d.ip_ovf = 1'b1;
        if (push_w[Q_OUT_FREE] && full_w[Q_OUT_FREE]) r_d.of_ovf = 1'b1;

        if (loc_rd) begin
            r_d.lrd = '0;
            if (loc_addr == RA_BASE) begin
                r_d.lrd = r_q.base;
            end else if (loc_addr == RA_CTRL) begin
                r_d.lrd[0] = r_q.en;
                r_d.lrd[CTRL_CODE_LSB +: CODE_W] = r_q.code;
            end else if (loc_addr == RA_STAT) begin
                r_d.lrd = stat_w;
            end else if (ptr_hit) begin
                r_d.lrd = ptr_rel[0] ? tail_w[ptr_rel[2:1]] : head_w[ptr_rel[2:1]];
            end else if (hit_lpa) begin
                r_d.lrd = (pop_w[Q_IN_POST] && !empty_w[Q_IN_POST]) ? mem_rd_a : EMPTY_WORD;
            end else if (hit_lpb) begin
                r_d.lrd = (pop_w[Q_OUT_FREE] && !empty_w[Q_OUT_FREE]) ? mem_rd_a : EMPTY_WORD;
            end
        end

        if (rem_rd) begin
            if (rem_sel)
                r_d.rrd = (pop_w[Q_OUT_POST] && !empty_w[Q_OUT_POST]) ? mem_rd_b : EMPTY_WORD;
            else
                r_d.rrd = (pop_w[Q_IN_FREE] && !empty_w[Q_IN_FREE]) ? mem_rd_b : EMPTY_WORD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.base   <= '0;
            r_q.en     <= 1'b0;
            r_q.code   <= RST_CODE;
            r_q.ip_ovf <= 1'b0;
            r_q.of_ovf <= 1'b0;
            r_q.lrd    <= '0;
            r_q.rrd    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign loc_rdata = r_q.lrd;
    assign rem_rdata = r_q.rrd;

    // ---------------- assertions ----------------
    assert_base_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && (loc_addr == RA_BASE) && (loc_wdata[ALIGN_BITS-1:0] != '0))
        |=> $stable(r_q.base));

    assert_empty_sentinel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_rd && !rem_sel && empty_w[Q_IN_FREE]) |=> (rem_rdata == EMPTY_WORD));

    assert_disabled_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && !r_q.en && (hit_lpa || hit_lpb)) |=> (loc_rdata == EMPTY_WORD));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ip_ovf && !(loc_wr && (loc_addr == RA_STAT) && loc_wdata[ST_IPOVF]))
        |=> r_q.ip_ovf);

    assert_post_attn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_w[Q_IN_POST] |-> attn);

    assert_mem_ports_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_a && mem_we_b && (mem_wa_a == mem_wa_b)));
endmodule

// File: tb/circq_mgr_tb.sv
module circq_mgr_tb_top;
    import qm_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] LEN = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_wr = 0, loc_rd = 0, rem_wr = 0, rem_rd = 0, rem_sel = 0;
    logic [3:0]  loc_addr = '0;
    logic [31:0] loc_wdata = '0, rem_wdata = '0;
    logic [31:0] loc_rdata, rem_rdata;
    logic        attn;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [31:0] lexp[$];
    string       ltag[$];
    logic [31:0] rexp[$];
    string       rtag[$];
    bit l_pend = 0, r_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    circq_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .rem_wr(rem_wr), .rem_rd(rem_rd), .rem_sel(rem_sel),
        .rem_wdata(rem_wdata), .rem_rdata(rem_rdata), .attn(attn)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after each strobe
    always @(negedge clk) begin
        if (l_pend) chk(loc_rdata, lexp.pop_front(), ltag.pop_front());
        if (r_pend) chk(rem_rdata, rexp.pop_front(), rtag.pop_front());
        l_pend = loc_rd;
        r_pend = rem_rd;
    end

    // driver: one cycle of strobes on both sides
    task automatic drive(input logic lw, input logic lr, input logic [3:0] la,
                         input logic [31:0] ld, input logic rw, input logic rr,
                         input logic rs, input logic [31:0] rd);
        loc_wr = lw; loc_rd = lr; loc_addr = la; loc_wdata = ld;
        rem_wr = rw; rem_rd = rr; rem_sel = rs; rem_wdata = rd;
        @(posedge clk); #1;
        loc_wr = 0; loc_rd = 0; rem_wr = 0; rem_rd = 0;
    endtask

    task automatic lwr(input logic [3:0] a, input logic [31:0] d);
        drive(1, 0, a, d, 0, 0, 0, 0);
    endtask
    task automatic lrd(input logic [3:0] a, input logic [31:0] e, input string t);
        lexp.push_back(e); ltag.push_back(t);
        drive(0, 1, a, 0, 0, 0, 0, 0);
    endtask
    task automatic rwr(input logic s, input logic [31:0] d);
        drive(0, 0, 4'd0, 0, 1, 0, s, d);
    endtask
    task automatic rrd(input logic s, input logic [31:0] e, input string t);
        rexp.push_back(e); rtag.push_back(t);
        drive(0, 0, 4'd0, 0, 0, 1, s, 0);
    endtask
    task automatic idle();
        drive(0, 0, 4'd0, 0, 0, 0, 0, 0);
    endtask

    function automatic logic [3:0] hd(input int q); return 4'(3 + 2*q); endfunction
    function automatic logic [3:0] tl(input int q); return 4'(4 + 2*q); endfunction
    function automatic logic [31:0] adv(input logic [31:0] p, input int n, input logic [31:0] lo);
        return lo + ((p - lo + 32'(n) * 4) % LEN);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] b, b2, h;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R11 reset state
        @(negedge clk);
        chk(loc_rdata, 0, "R11 loc_rdata");
        chk(rem_rdata, 0, "R11 rem_rdata");
        chk(32'(attn), 0, "R11 attn");
        @(posedge clk); #1;
        lrd(RA_BASE, 0, "R11 base");
        lrd(RA_CTRL, 32'h100, "R10 ctrl reset");
        lrd(RA_STAT, 0, "R11 stat");
        for (int q = 0; q < 4; q++) begin
            lrd(hd(q), 32'(q) * LEN, "R11 head");
            lrd(tl(q), 32'(q) * LEN, "R11 tail");
        end

        // R1 alignment
        lwr(RA_BASE, 32'h0012_3000);
        lrd(RA_BASE, 0, "R1 misaligned rejected");
        lrd(hd(1), LEN, "R1 no init on reject");
        b = 32'h0030_0000;
        lwr(RA_BASE, b);
        lrd(RA_BASE, b, "R1 aligned accepted");
        for (int q = 0; q < 4; q++) begin
            lrd(hd(q), b + 32'(q) * LEN, "R2 head init");
            lrd(tl(q), b + 32'(q) * LEN, "R2 tail init");
        end

        // R9 disabled ports
        rwr(0, 32'hAAAA_0001);
        rrd(0, EMPTY_WORD, "R9 remote read disabled");
        lrd(RA_LPORT_A, EMPTY_WORD, "R9 local read disabled");
        lrd(hd(1), b + LEN, "R9 write ignored");
        lrd(RA_STAT, 0, "R9 stat");

        lwr(RA_CTRL, 32'h101);
        lrd(RA_CTRL, 32'h101, "R10 ctrl accepted");

        // R3 inbound post via remote push, local pop
        rwr(0, 32'h1111); rwr(0, 32'h2222); rwr(0, 32'h3333);
        lrd(RA_STAT, 32'h20, "R8 post set");
        @(negedge clk); chk(32'(attn), 1, "R8 attn");
        @(posedge clk); #1;
        lrd(hd(1), b + LEN + 12, "R3 head advance");
        lrd(RA_LPORT_A, 32'h1111, "R3 fifo 1");
        lrd(RA_LPORT_A, 32'h2222, "R3 fifo 2");
        lrd(RA_LPORT_A, 32'h3333, "R3 fifo 3");
        lrd(RA_STAT, 0, "R8 post cleared");
        @(negedge clk); chk(32'(attn), 0, "R8 attn cleared");
        @(posedge clk); #1;
        lrd(RA_LPORT_A, EMPTY_WORD, "R5 empty pop");
        lrd(tl(1), b + LEN + 12, "R5 tail unmoved");

        // R3 the other three queues
        lwr(RA_LPORT_A, 32'hF0F0_0001);
        lwr(RA_LPORT_A, 32'hF0F0_0002);
        rrd(0, 32'hF0F0_0001, "R3 inbound free 1");
        rrd(0, 32'hF0F0_0002, "R3 inbound free 2");
        rrd(0, EMPTY_WORD, "R5 inbound free empty");
        lwr(RA_LPORT_B, 32'h0B0B_0001);
        rrd(1, 32'h0B0B_0001, "R3 outbound post");
        rwr(1, 32'h0F0F_0001);
        lrd(RA_LPORT_B, 32'h0F0F_0001, "R3 outbound free");
        lrd(RA_LPORT_B, EMPTY_WORD, "R5 outbound free empty");

        // R13 hold
        lrd(RA_BASE, b, "R13 read");
        idle();
        @(negedge clk); chk(loc_rdata, b, "R13 hold");
        @(posedge clk); #1;

        // R6 / R4 fill inbound post across the wrap
        h = b + LEN + 12;
        for (int i = 0; i < 511; i++) rwr(0, 32'h5000_0000 + 32'(i));
        rwr(0, 32'h0000_DEAD);
        lrd(RA_STAT, 32'hA0, "R7 ip overflow");
        lrd(hd(1), adv(h, 511, b + LEN), "R6 head held");
        for (int i = 0; i < 511; i++) lrd(RA_LPORT_A, 32'h5000_0000 + 32'(i), "R4 wrap order");
        lrd(RA_LPORT_A, EMPTY_WORD, "R6 refused not stored");
        lrd(tl(1), adv(h, 511, b + LEN), "R4 tail wrapped");
        lrd(RA_STAT, 32'h80, "R7 sticky");
        lwr(RA_STAT, 32'h80);
        lrd(RA_STAT, 0, "R7 cleared");

        // R12 same-cycle push and pop
        lexp.push_back(EMPTY_WORD); ltag.push_back("R12 pop empty with push");
        drive(0, 1, RA_LPORT_A, 0, 1, 0, 0, 32'hC001);
        lexp.push_back(32'hC001); ltag.push_back("R12 pop old with push");
        drive(0, 1, RA_LPORT_A, 0, 1, 0, 0, 32'hC002);
        lrd(RA_LPORT_A, 32'hC002, "R12 pushed word");

        // R7 set wins over clear, on outbound free
        b2 = 32'h0050_0000;
        lwr(RA_BASE, b2);
        lrd(hd(2), b2 + 2 * LEN, "R2 rebase");
        for (int i = 0; i < 511; i++) rwr(1, 32'h6000_0000 + 32'(i));
        drive(1, 0, RA_STAT, 32'h100, 1, 0, 1, 32'hBAD);
        lrd(RA_STAT, 32'h100, "R7 set wins");
        lrd(hd(2), b2 + 2 * LEN + 511 * 4, "R6 of head held");
        lwr(RA_STAT, 32'h100);
        lrd(RA_STAT, 0, "R7 of cleared");

        // R9 disable keeps pointers
        lwr(RA_CTRL, 32'h100);
        lrd(hd(2), b2 + 2 * LEN + 511 * 4, "R9 head intact");
        rrd(1, EMPTY_WORD, "R9 disabled remote");
        lwr(RA_CTRL, 32'h101);
        lrd(RA_LPORT_B, 32'h6000_0000, "R9 entries intact");

        // R10 bad size codes
        lwr(RA_CTRL, 32'h000);
        lrd(RA_CTRL, 32'h101, "R10 code 0 rejected");
        lwr(RA_CTRL, 32'h200);
        lrd(RA_CTRL, 32'h101, "R10 code 2 rejected");

        idle(); idle();
        finish_run();
    end
endmodule